// File: doc/BRIEF.md
# Cache-Block Operation Decode and Privilege Gate

This block sits in an instruction decode path and recognises the four cache-block instructions: clean, flush, invalidate and zero. For each recognised instruction it checks whether the current privilege level may run that operation. The enables come from a machine-level and a supervisor-level environment-configuration field. The block then either issues a one-hot operation together with the base-register index, or raises an illegal-instruction indication.

An invalidate that is allowed at the current privilege, but whose "full invalidate" permission bit resolves to 0, is issued as a flush. Words that are not cache-block operations produce no output at all, so the rest of the decoder can handle them.

The result is captured in one register stage and appears on the outputs one clock after it is presented. The reset `rst_n` is asynchronous and active low. Its release must already be synchronous to `clk`.

Top module: `cbo_gate`

## Requirements
- R1: A word is treated as a cache-block operation only when `in_vld` is 1, bits [6:0] are 0001111, bits [14:12] are 010, bits [11:7] are zero and the 12-bit field in bits [31:20] is 0, 1, 2 or 4. Any other word leaves `op_vld` and `illegal` at 0 in the following cycle.
- R2: The field value selects the operation: 1 is clean, 2 is flush, 0 is invalidate and 4 is zero. These map to `op_onehot` bit 0 (clean), bit 1 (flush), bit 2 (invalidate) and bit 3 (zero). When `op_vld` is 1, exactly one bit of `op_onehot` is set. When `op_vld` is 0, `op_onehot` is all zero.
- R3: At machine privilege (`priv` = 2'b11), every operation is permitted and an invalidate stays an invalidate, whatever the enable bits hold.
- R4: At supervisor privilege (`priv` = 2'b01), an operation is permitted only when its machine-level enable bit is 1. The supervisor-level bits have no effect.
- R5: At user privilege (`priv` = 2'b00, with 2'b10 treated the same way), an operation needs its machine-level bit at 1. When `has_smode` is 1 it also needs its supervisor-level bit at 1. When `has_smode` is 0 the supervisor-level bits are ignored.
- R6: Clean and flush are both governed by the `*_clnflush` bits. Invalidate is governed by bit 0 of the `*_inval` fields. Zero is governed by the `*_zero` bits.
- R7: A permitted invalidate is issued as a flush (`op_onehot` bit 1) when bit 1 of the `*_inval` fields, resolved by the rules of R3 to R5, comes out as 0.
- R8: A recognised operation that is not permitted sets `illegal` to 1 with `op_vld` at 0. `op_vld` and `illegal` are never both 1.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R10: `op_rs1` carries bits [19:15] of the issued word while `op_vld` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Privilege: 11 machine, 01 supervisor, 00/10 user |
| has_smode | input | 1 | Supervisor mode is implemented |
| men_clnflush | input | 1 | Machine-level clean/flush enable |
| men_inval | input | 2 | Machine-level invalidate enable field |
| men_zero | input | 1 | Machine-level zero enable |
| sen_clnflush | input | 1 | Supervisor-level clean/flush enable |
| sen_inval | input | 2 | Supervisor-level invalidate enable field |
| sen_zero | input | 1 | Supervisor-level zero enable |
| op_vld | output | 1 | An operation is issued |
| op_onehot | output | 4 | Issued operation, one-hot |
| op_rs1 | output | 5 | Base register index of the issued operation |
| illegal | output | 1 | Recognised operation refused at this privilege |

## Verification
The bound assertions run on every cycle. They cover the following properties:
- `op_vld` and `illegal` never both high, and the one-hot shape of `op_onehot`.
- Idle outputs after a cycle with no valid word.
- Silence for words with a foreign opcode.
- Machine mode always issuing.
- Supervisor refusal when the machine enable is clear.
- The base-register index tracking the issued word.

The full enable matrix needs the bench's scenarios to show it. That covers the supervisor bit being ignored without supervisor mode, the invalidate-to-flush downgrade at each privilege, the shared clean/flush enable and the rejection of unlisted field values.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int IMM_W     = 12;
  localparam int INV_W     = 2;
  localparam int NUM_OPS   = 4;
  localparam int NUM_EN    = 4;

  localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
  localparam logic [2:0] F3_CBO       = 3'b010;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  // one-hot output positions
  localparam int OH_CLEAN = 0;
  localparam int OH_FLUSH = 1;
  localparam int OH_INVAL = 2;
  localparam int OH_ZERO  = 3;

  // enable resolver slots
  localparam int EN_CF       = 0;
  localparam int EN_INV      = 1;
  localparam int EN_INV_FULL = 2;
  localparam int EN_ZERO     = 3;

  typedef enum logic [1:0] {
    OP_CLEAN = 2'd0,
    OP_FLUSH = 2'd1,
    OP_INVAL = 2'd2,
    OP_ZERO  = 2'd3
  } cbo_op_e;
endpackage

// File: rtl/cbo_decode.sv
module cbo_decode
  import cbo_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr,
  output logic                 hit,
  output cbo_op_e              op,
  output logic [REG_IDX_W-1:0] rs1
);
  logic [6:0]       opcode;
  logic [4:0]       rd;
  logic [2:0]       f3;
  logic [IMM_W-1:0] imm;
  logic             frame_ok;

  assign opcode   = instr[6:0];
  assign rd       = instr[11:7];
  assign f3       = instr[14:12];
  assign rs1      = instr[19:15];
  assign imm      = instr[31:20];
  assign frame_ok = (opcode == OPC_MISC_MEM) && (f3 == F3_CBO) && (rd == '0);

  always_comb begin
    hit = 1'b0;
    op  = OP_CLEAN;
    if (frame_ok) begin
      case (imm)
        12'd0:   begin hit = 1'b1; op = OP_INVAL; end
        12'd1:   begin hit = 1'b1; op = OP_CLEAN; end
        12'd2:   begin hit = 1'b1; op = OP_FLUSH; end
        12'd4:   begin hit = 1'b1; op = OP_ZERO;  end
        default: begin hit = 1'b0; op = OP_CLEAN; end
      endcase
    end
  end
endmodule

// File: rtl/cbo_feat_en.sv
module cbo_feat_en
  import cbo_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       has_smode,
  input  logic       m_bit,
  input  logic       s_bit,
  output logic       en
);
  always_comb begin
    case (priv)
      PRIV_M:  en = 1'b1;
      PRIV_S:  en = m_bit;
      default: en = m_bit & (~has_smode | s_bit);
    endcase
  end
endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
  import cbo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [1:0]           priv,
  input  logic                 has_smode,
  input  logic                 men_clnflush,
  input  logic [INV_W-1:0]     men_inval,
  input  logic                 men_zero,
  input  logic                 sen_clnflush,
  input  logic [INV_W-1:0]     sen_inval,
  input  logic                 sen_zero,
  output logic                 op_vld,
  output logic [NUM_OPS-1:0]   op_onehot,
  output logic [REG_IDX_W-1:0] op_rs1,
  output logic                 illegal
);
  logic                 dec_hit;
  cbo_op_e              dec_op;
  logic [REG_IDX_W-1:0] dec_rs1;
  logic [NUM_EN-1:0]    m_bits, s_bits, en_vec;

  logic                 allowed;
  logic [NUM_OPS-1:0]   oh_sel;
  logic                 vld_d, ill_d, upd;
  logic [NUM_OPS-1:0]   oh_d;
  logic [REG_IDX_W-1:0] rs1_d;

  cbo_decode u_dec (
    .instr (instr),
    .hit   (dec_hit),
    .op    (dec_op),
    .rs1   (dec_rs1)
  );

  assign m_bits[EN_CF]       = men_clnflush;
  assign m_bits[EN_INV]      = men_inval[0];
  assign m_bits[EN_INV_FULL] = men_inval[1];
  assign m_bits[EN_ZERO]     = men_zero;
  assign s_bits[EN_CF]       = sen_clnflush;
  assign s_bits[EN_INV]      = sen_inval[0];
  assign s_bits[EN_INV_FULL] = sen_inval[1];
  assign s_bits[EN_ZERO]     = sen_zero;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    cbo_feat_en u_en (
      .priv      (priv),
      .has_smode (has_smode),
      .m_bit     (m_bits[g]),
      .s_bit     (s_bits[g]),
      .en        (en_vec[g])
    );
  end

  // next-state
  always_comb begin
    allowed = 1'b0;
    oh_sel  = '0;
    case (dec_op)
      OP_CLEAN: begin allowed = en_vec[EN_CF];   oh_sel[OH_CLEAN] = 1'b1; end
      OP_FLUSH: begin allowed = en_vec[EN_CF];   oh_sel[OH_FLUSH] = 1'b1; end
      OP_INVAL: begin
        allowed = en_vec[EN_INV];
        if (en_vec[EN_INV_FULL]) oh_sel[OH_INVAL] = 1'b1;
        else                     oh_sel[OH_FLUSH] = 1'b1;
      end
      OP_ZERO:  begin allowed = en_vec[EN_ZERO]; oh_sel[OH_ZERO]  = 1'b1; end
      default:  begin allowed = 1'b0;            oh_sel = '0;             end
    endcase
    vld_d = in_vld & dec_hit & allowed;
    ill_d = in_vld & dec_hit & ~allowed;
    oh_d  = vld_d ? oh_sel : '0;
    rs1_d = vld_d ? dec_rs1 : '0;
    upd   = in_vld | op_vld | illegal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_vld    <= 1'b0;
      op_onehot <= '0;
      op_rs1    <= '0;
      illegal   <= 1'b0;
    end else if (upd) begin
      op_vld    <= vld_d;
      op_onehot <= oh_d;
      op_rs1    <= rs1_d;
      illegal   <= ill_d;
    end
  end
endmodule

// File: rtl/cbo_gate_chk.sv
module cbo_gate_chk
  import cbo_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic [INSTR_W-1:0]   instr,
  input logic [1:0]           priv,
  input logic                 has_smode,
  input logic                 men_clnflush,
  input logic [INV_W-1:0]     men_inval,
  input logic                 men_zero,
  input logic                 sen_clnflush,
  input logic [INV_W-1:0]     sen_inval,
  input logic                 sen_zero,
  input logic                 op_vld,
  input logic [NUM_OPS-1:0]   op_onehot,
  input logic [REG_IDX_W-1:0] op_rs1,
  input logic                 illegal
);
  logic word_is_cbo;
  assign word_is_cbo = (instr[6:0] == 7'b0001111) && (instr[14:12] == 3'b010) &&
                       (instr[11:7] == 5'd0) &&
                       ((instr[31:20] == 12'd0) || (instr[31:20] == 12'd1) ||
                        (instr[31:20] == 12'd2) || (instr[31:20] == 12'd4));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_vld && illegal));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |-> ($countones(op_onehot) == 1));

  p_quiet_oh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |-> (op_onehot == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!op_vld && !illegal));

  p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && instr[6:0] != 7'b0001111) |=> (!op_vld && !illegal));

  p_machine_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && word_is_cbo && priv == 2'b11) |=> op_vld);

  p_super_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && word_is_cbo && priv == 2'b01 && instr[31:20] == 12'd4 && !men_zero)
      |=> illegal);

  p_rs1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (op_vld ? (op_rs1 == $past(instr[19:15])) : (op_rs1 == '0)));
endmodule

bind cbo_gate cbo_gate_chk u_chk (.*);

// File: tb/sim_cbo_gate.sv
`timescale 1ns/1ps
module sim_cbo_gate;
  import cbo_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] instr;
  logic [1:0]  priv;
  logic        has_smode;
  logic        men_clnflush, men_zero, sen_clnflush, sen_zero;
  logic [1:0]  men_inval, sen_inval;
  logic        op_vld, illegal;
  logic [3:0]  op_onehot;
  logic [4:0]  op_rs1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cbo_gate u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .instr(instr), .priv(priv),
    .has_smode(has_smode), .men_clnflush(men_clnflush), .men_inval(men_inval),
    .men_zero(men_zero), .sen_clnflush(sen_clnflush), .sen_inval(sen_inval),
    .sen_zero(sen_zero), .op_vld(op_vld), .op_onehot(op_onehot),
    .op_rs1(op_rs1), .illegal(illegal)
  );

  // en nibble: [3] zero, [2] inval bit1, [1] inval bit0, [0] clean/flush
  typedef struct packed {
    logic [1:0]  pv;
    logic        hs;
    logic [3:0]  men;
    logic [3:0]  sen;
    logic [11:0] imm;
    logic [4:0]  rs;
    logic        ill;
    logic [3:0]  oh;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b1, 4'b0000, 4'b0000, 12'd1, 5'd5,  1'b0, 4'b0001}, // R3 clean
    '{2'b11, 1'b1, 4'b0000, 4'b0000, 12'd0, 5'd6,  1'b0, 4'b0100}, // R3 R7 inval kept
    '{2'b01, 1'b1, 4'b0001, 4'b0000, 12'd2, 5'd7,  1'b0, 4'b0010}, // R4 flush
    '{2'b01, 1'b1, 4'b0000, 4'b1111, 12'd1, 5'd8,  1'b1, 4'b0000}, // R4 refused
    '{2'b01, 1'b1, 4'b0010, 4'b0000, 12'd0, 5'd9,  1'b0, 4'b0010}, // R7 downgrade
    '{2'b01, 1'b1, 4'b0110, 4'b0000, 12'd0, 5'd10, 1'b0, 4'b0100}, // R7 full inval
    '{2'b00, 1'b1, 4'b1000, 4'b0000, 12'd4, 5'd11, 1'b1, 4'b0000}, // R5 sup bit needed
    '{2'b00, 1'b1, 4'b1000, 4'b1000, 12'd4, 5'd12, 1'b0, 4'b1000}, // R5 zero
    '{2'b00, 1'b0, 4'b1000, 4'b0000, 12'd4, 5'd13, 1'b0, 4'b1000}, // R5 no smode
    '{2'b00, 1'b1, 4'b0110, 4'b0010, 12'd0, 5'd14, 1'b0, 4'b0010}, // R7 user downgrade
    '{2'b00, 1'b1, 4'b0001, 4'b1110, 12'd1, 5'd15, 1'b1, 4'b0000}, // R6 cf sup clear
    '{2'b01, 1'b1, 4'b1110, 4'b1111, 12'd2, 5'd16, 1'b1, 4'b0000}, // R6 flush needs cf
    '{2'b00, 1'b0, 4'b0110, 4'b0000, 12'd0, 5'd17, 1'b0, 4'b0100}, // R5 R7 no smode
    '{2'b10, 1'b1, 4'b0001, 4'b0000, 12'd2, 5'd31, 1'b1, 4'b0000}  // R5 2'b10 as user
  };

  function automatic logic [31:0] mk(input logic [11:0] imm, input logic [4:0] rs,
                                     input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [6:0] opc);
    return {imm, rs, f3, rd, opc};
  endfunction

  task automatic check(input string req, input logic ev, input logic ei,
                       input logic [3:0] eo, input logic [4:0] er);
    checks++;
    if (op_vld !== ev || illegal !== ei || op_onehot !== eo || op_rs1 !== er) begin
      fails++;
      $display("FAIL %s: got vld=%b ill=%b oh=%b rs1=%0d, expected vld=%b ill=%b oh=%b rs1=%0d",
               req, op_vld, illegal, op_onehot, op_rs1, ev, ei, eo, er);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic [1:0] pv,
                       input logic hs, input logic [3:0] me, input logic [3:0] se);
    @(negedge clk);
    in_vld = v; instr = w; priv = pv; has_smode = hs;
    men_clnflush = me[0]; men_inval = me[2:1]; men_zero = me[3];
    sen_clnflush = se[0]; sen_inval = se[2:1]; sen_zero = se[3];
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b1; instr = mk(12'd1, 5'd3, 3'b010, 5'd0, 7'b0001111);
    priv = 2'b11; has_smode = 1'b1;
    men_clnflush = 1'b1; men_inval = 2'b11; men_zero = 1'b1;
    sen_clnflush = 1'b1; sen_inval = 2'b11; sen_zero = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 1'b0, 4'b0000, 5'd0);
    rst_n = 1'b1;
    in_vld = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, mk(VECS[i].imm, VECS[i].rs, 3'b010, 5'd0, 7'b0001111),
            VECS[i].pv, VECS[i].hs, VECS[i].men, VECS[i].sen);
      check($sformatf("R2 R6 R8 R10 vec%0d", i), ~VECS[i].ill, VECS[i].ill, VECS[i].oh,
            VECS[i].ill ? 5'd0 : VECS[i].rs);
    end

    // R1 unlisted field values and frame mismatches, all enables open
    drive(1'b1, mk(12'd3, 5'd4, 3'b010, 5'd0, 7'b0001111), 2'b11, 1'b1, 4'hF, 4'hF);
    check("R1 imm3", 1'b0, 1'b0, 4'b0000, 5'd0);
    drive(1'b1, mk(12'd8, 5'd4, 3'b010, 5'd0, 7'b0001111), 2'b11, 1'b1, 4'hF, 4'hF);
    check("R1 imm8", 1'b0, 1'b0, 4'b0000, 5'd0);
    drive(1'b1, mk(12'd1, 5'd4, 3'b010, 5'd2, 7'b0001111), 2'b11, 1'b1, 4'hF, 4'hF);
    check("R1 rd nonzero", 1'b0, 1'b0, 4'b0000, 5'd0);
    drive(1'b1, mk(12'd2, 5'd4, 3'b001, 5'd0, 7'b0001111), 2'b00, 1'b1, 4'h0, 4'h0);
    check("R1 funct3", 1'b0, 1'b0, 4'b0000, 5'd0);
    drive(1'b1, mk(12'd4, 5'd4, 3'b010, 5'd0, 7'b0010011), 2'b00, 1'b1, 4'h0, 4'h0);
    check("R1 opcode", 1'b0, 1'b0, 4'b0000, 5'd0);
    drive(1'b0, mk(12'd4, 5'd4, 3'b010, 5'd0, 7'b0001111), 2'b11, 1'b1, 4'hF, 4'hF);
    check("R1 in_vld low", 1'b0, 1'b0, 4'b0000, 5'd0);

    // R9 one-cycle latency: result visible only after the next rising edge
    @(negedge clk);
    in_vld = 1'b1; instr = mk(12'd4, 5'd21, 3'b010, 5'd0, 7'b0001111); priv = 2'b11;
    #1;
    check("R9 not before edge", 1'b0, 1'b0, 4'b0000, 5'd0);
    @(negedge clk);
    check("R9 after edge", 1'b1, 1'b0, 4'b1000, 5'd21);
    in_vld = 1'b0;
    @(negedge clk);
    check("R9 returns idle", 1'b0, 1'b0, 4'b0000, 5'd0);

    // R4 supervisor bits have no effect at supervisor privilege
    drive(1'b1, mk(12'd4, 5'd2, 3'b010, 5'd0, 7'b0001111), 2'b01, 1'b1, 4'b1000, 4'b0000);
    check("R4 sup bits ignored", 1'b1, 1'b0, 4'b1000, 5'd2);

    // R8 back-to-back issue then refusal
    drive(1'b1, mk(12'd1, 5'd1, 3'b010, 5'd0, 7'b0001111), 2'b00, 1'b1, 4'b0001, 4'b0001);
    check("R6 clean user", 1'b1, 1'b0, 4'b0001, 5'd1);
    drive(1'b1, mk(12'd0, 5'd1, 3'b010, 5'd0, 7'b0001111), 2'b00, 1'b1, 4'b0001, 4'b0001);
    check("R8 inval refused", 1'b0, 1'b1, 4'b0000, 5'd0);

    // R9 reset mid-stream clears outputs
    drive(1'b1, mk(12'd2, 5'd9, 3'b010, 5'd0, 7'b0001111), 2'b11, 1'b1, 4'h0, 4'h0);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", 1'b0, 1'b0, 4'b0000, 5'd0);
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule